// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits in the write path between a register bus and a peripheral's register file. It filters the write strobe so that protected registers can only be modified after software has opened the gate. Opening takes two writes in a fixed order: a first 32-bit magic word to one kick register, then a different 32-bit magic word to a second kick register. Any other value written to either kick register, zero included, closes the gate again at once. Reads never go through this block, so they are never affected.

The usual flow is short. Software opens the gate, issues a small batch of writes to time, alarm, interrupt-enable, status-clear or power-control registers, and then writes zero to a kick register to close it. Which word addresses count as protected is set by a per-word mask parameter. The two kick registers themselves always accept writes. The block keeps a three-state lock machine: locked, armed (first key seen) and open. The open state is exported as a single lock flag.

Top module: `wprot_gate`

## Requirements
- R1: While and after reset, with no kick write since, `locked` is 1.
- R2: A strobed write to a protected word (mask bit 1, not a kick register) while `locked` is 1 gives `wr_pass` 0 in that same cycle. With the default mask, words 0 to 31 (byte offsets 0x00 to 0x7C) are protected.
- R3: A strobed write to an unprotected word (mask bit 0; by default offsets 0x80 to 0xFC) gives `wr_pass` 1 whatever the lock state.
- R4: A strobed write to either kick register (byte offset 0x6C or 0x70) gives `wr_pass` 1 whatever the lock state.
- R5: Writing 0x83E70B13 to offset 0x6C and then 0x95A4F1E0 to offset 0x70 clears `locked` on the clock edge that takes the second write. From the next cycle on, protected writes pass. The two low address bits are ignored when decoding.
- R6: Writing the second key to 0x70 while the gate is locked (first key not seen) leaves `locked` at 1.
- R7: A write of any value other than that register's own key to either kick register sets `locked` to 1 on that edge, from any state. This includes zero and values one bit away from a key.
- R8: Writes to addresses other than the kick registers do not change the lock state. An armed gate stays armed across them, and protected writes made while armed are still dropped.
- R9: `wr_pass` is 1 only in a cycle where `wr_en` is 1.
- R10: Writing the first key to 0x6C while the gate is open moves it back to armed, so `locked` reads 1 until the second key follows.
- R11: A key written to the other kick register (second key to 0x6C, or first key to 0x70 after arming) counts as a wrong value and locks the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (8) | Bus write byte address |
| wr_data | input | DATA_W (32) | Bus write data |
| wr_pass | output | 1 | Filtered write strobe to the register file |
| locked | output | 1 | 1 unless the gate is open |

## Verification
The bench sweeps every word address of the default configuration, both locked and open. A mask decoded off by one word, or kick registers that get blocked while locked, would show up as a wrong strobe at one specific address. It drives the key sequences in the wrong order, on swapped addresses, with zero, and with values one bit off a key. A gate that opens on the second key alone, or that compares only part of the word, would report `locked` low where it should be high. It also checks that the gate stays armed across unrelated writes and that re-arming an open gate closes it. A design that reset its sequence on every bus write, or kept the gate open on a repeated first key, fails those checks.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    // Classification of a bus write address
    typedef enum logic [1:0] {
        ACC_PROT  = 2'd0,
        ACC_FREE  = 2'd1,
        ACC_KICK0 = 2'd2,
        ACC_KICK1 = 2'd3
    } acc_cls_t;

    // Lock machine states
    typedef enum logic [1:0] {
        GS_LOCKED = 2'd0,
        GS_ARMED  = 2'd1,
        GS_OPEN   = 2'd2
    } gate_st_t;

    localparam logic [31:0] DEF_KEY0 = 32'h83E7_0B13;
    localparam logic [31:0] DEF_KEY1 = 32'h95A4_F1E0;

    function automatic logic is_kick(input acc_cls_t c);
        return (c == ACC_KICK0) || (c == ACC_KICK1);
    endfunction

    // Next lock state for one strobed write
    function automatic gate_st_t step_state(input gate_st_t cur,
                                            input acc_cls_t c,
                                            input logic     key_ok);
        gate_st_t nxt;
        nxt = cur;
        case (c)
            ACC_KICK0: nxt = key_ok ? GS_ARMED : GS_LOCKED;
            ACC_KICK1: nxt = (key_ok && (cur == GS_ARMED || cur == GS_OPEN))
                             ? GS_OPEN : GS_LOCKED;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
    import wpg_pkg::*;
#(
    parameter int                          ADDR_W    = 8,
    parameter int                          DATA_W    = 32,
    parameter logic [ADDR_W-1:0]           KICK0_OFF = 8'h6C,
    parameter logic [ADDR_W-1:0]           KICK1_OFF = 8'h70,
    parameter logic [DATA_W-1:0]           KEY0      = DATA_W'(DEF_KEY0),
    parameter logic [DATA_W-1:0]           KEY1      = DATA_W'(DEF_KEY1),
    parameter int                          NW        = 1 << (ADDR_W - 2),
    parameter logic [NW-1:0]               PROT_MASK = {NW{1'b1}}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output acc_cls_t          cls,
    output logic              key_ok
);
    localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'(3);

    logic              hit0, hit1, prot_bit;
    logic [ADDR_W-1:0] word;

    always_comb begin
        hit0     = (addr | LOW_BITS) == (KICK0_OFF | LOW_BITS);
        hit1     = (addr | LOW_BITS) == (KICK1_OFF | LOW_BITS);
        word     = addr >> 2;
        prot_bit = |(PROT_MASK & (NW'(1) << word));

        if (hit0)          cls = ACC_KICK0;
        else if (hit1)     cls = ACC_KICK1;
        else if (prot_bit) cls = ACC_PROT;
        else               cls = ACC_FREE;

        key_ok = (hit0 && data == KEY0) || (hit1 && !hit0 && data == KEY1);
    end
endmodule

// File: rtl/wpg_lock_fsm.sv
module wpg_lock_fsm
    import wpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  acc_cls_t cls,
    input  logic     key_ok,
    output gate_st_t st,
    output logic     locked
);
    always_ff @(posedge clk) begin
        if (rst)        st <= GS_LOCKED;
        else if (wr_en) st <= step_state(st, cls, key_ok);
    end

    assign locked = (st != GS_OPEN);
endmodule

// File: rtl/wpg_strobe_filter.sv
module wpg_strobe_filter
    import wpg_pkg::*;
(
    input  logic     wr_en,
    input  acc_cls_t cls,
    input  gate_st_t st,
    output logic     wr_pass
);
    logic allowed;

    always_comb begin
        case (cls)
            ACC_PROT: allowed = (st == GS_OPEN);
            default:  allowed = 1'b1;
        endcase
        wr_pass = wr_en && allowed;
    end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wpg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KICK0_OFF = 8'h6C,
    parameter logic [ADDR_W-1:0] KICK1_OFF = 8'h70,
    parameter logic [DATA_W-1:0] KEY0      = DATA_W'(DEF_KEY0),
    parameter logic [DATA_W-1:0] KEY1      = DATA_W'(DEF_KEY1),
    parameter int                NW        = 1 << (ADDR_W - 2),
    parameter logic [NW-1:0]     PROT_MASK = NW'(64'h0000_0000_FFFF_FFFF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_pass,
    output logic              locked
);
    acc_cls_t acc_cls;
    logic     key_ok;
    gate_st_t gate_st;

    wpg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KICK0_OFF(KICK0_OFF), .KICK1_OFF(KICK1_OFF),
        .KEY0(KEY0), .KEY1(KEY1),
        .NW(NW), .PROT_MASK(PROT_MASK)
    ) u_dec (
        .addr(wr_addr), .data(wr_data), .cls(acc_cls), .key_ok(key_ok)
    );

    wpg_lock_fsm u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cls(acc_cls),
        .key_ok(key_ok), .st(gate_st), .locked(locked)
    );

    wpg_strobe_filter u_flt (
        .wr_en(wr_en), .cls(acc_cls), .st(gate_st), .wr_pass(wr_pass)
    );
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk
    import wpg_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     wr_en,
    input logic     wr_pass,
    input logic     locked,
    input acc_cls_t cls,
    input logic     key_ok,
    input gate_st_t st
);
    // R1
    rst_locked_chk: assert property (@(posedge clk) rst |=> locked);

    // R9
    pass_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pass |-> wr_en);

    // R2
    drop_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls == ACC_PROT && locked) |-> !wr_pass);

    // R3
    free_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls == ACC_FREE) |-> wr_pass);

    // R4
    kick_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_kick(cls)) |-> wr_pass);

    // R5
    arm_then_open_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls == ACC_KICK1 && key_ok && st == GS_ARMED) |=> !locked);

    // R6
    open_only_by_key1_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(wr_en && cls == ACC_KICK1 && key_ok));

    // R7
    bad_key_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_kick(cls) && !key_ok) |=> (st == GS_LOCKED));

    // R8
    other_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || !is_kick(cls)) |=> (st == $past(st)));

    // R10
    rearm_locks_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls == ACC_KICK0 && key_ok) |=> (locked && st == GS_ARMED));
endmodule

bind wprot_gate wprot_gate_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pass(wr_pass),
    .locked(locked), .cls(acc_cls), .key_ok(key_ok), .st(gate_st)
);

// File: tb/tb_wprot_gate.sv
`timescale 1ns/100ps
module tb_wprot_gate;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam logic [7:0]  A0 = 8'h6C;
    localparam logic [7:0]  A1 = 8'h70;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_pass, locked;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wprot_gate dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_pass(wr_pass), .locked(locked)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One strobed write; checks the strobe in its cycle, then idles a cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic exp_pass, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 check(tag, wr_pass, exp_pass);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check({tag, " idle strobe R9"}, wr_pass, 1'b0);
    endtask

    function automatic logic is_kick_w(input int w);
        return (w == 27) || (w == 28);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 locked in reset", locked, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        #1 check("R1 locked after reset", locked, 1'b1);
        check("R9 no strobe no pass", wr_pass, 1'b0);

        // Locked sweep over every word, non-key data
        for (int w = 0; w < 64; w++) begin
            logic exp;
            exp = is_kick_w(w) || (w >= 32);
            wr(8'(w * 4), 32'h1111_1111 * 32'(w % 7) + 32'h5, exp,
               is_kick_w(w) ? "R4 kick passes locked" :
               (w >= 32 ? "R3 free passes locked" : "R2 protected dropped"));
            check("R1 stays locked in sweep", locked, 1'b1);
        end

        // Unlock
        wr(A0, K0, 1'b1, "R4 key0 write");
        check("R5 armed still locked", locked, 1'b1);
        wr(A1, K1, 1'b1, "R4 key1 write");
        check("R5 open after sequence", locked, 1'b0);

        // Open sweep, skipping kick words
        for (int w = 0; w < 64; w++) begin
            if (!is_kick_w(w)) begin
                wr(8'(w * 4 + (w % 4)), 32'hDEAD_0000 + 32'(w), 1'b1,
                   w >= 32 ? "R3 free passes open" : "R5 protected passes open");
                check("R8 stays open", locked, 1'b0);
            end
        end

        // Zero to first kick relocks
        wr(A0, 32'h0, 1'b1, "R4 zero kick0");
        check("R7 zero kick0 locks", locked, 1'b1);
        wr(8'h10, 32'h1, 1'b0, "R2 dropped after relock");

        // Zero to second kick relocks
        wr(A0, K0, 1'b1, "R4 k0"); wr(A1, K1, 1'b1, "R4 k1");
        check("R5 open again", locked, 1'b0);
        wr(A1, 32'h0, 1'b1, "R4 zero kick1");
        check("R7 zero kick1 locks", locked, 1'b1);

        // Second key alone
        wr(A1, K1, 1'b1, "R4 k1 alone");
        check("R6 key1 alone stays locked", locked, 1'b1);
        wr(8'h04, 32'h2, 1'b0, "R6 protected dropped");
        // Reverse order
        wr(A0, K0, 1'b1, "R4 k0 after k1");
        check("R6 reverse order locked", locked, 1'b1);
        wr(8'h08, 32'h3, 1'b0, "R8 protected dropped while armed");
        wr(8'h84, 32'h3, 1'b1, "R3 free while armed");
        wr(A1, K1, 1'b1, "R4 k1 finishing");
        check("R8 arm survives other writes", locked, 1'b0);

        // Re-arm while open
        wr(A0, K0, 1'b1, "R4 k0 while open");
        check("R10 rearm locks", locked, 1'b1);
        wr(8'h00, 32'h4, 1'b0, "R10 protected dropped after rearm");
        wr(A1, K1, 1'b1, "R4 k1 after rearm");
        check("R10 reopens", locked, 1'b0);

        // Swapped keys
        wr(A0, K1, 1'b1, "R4 k1 on kick0");
        check("R11 key1 on kick0 locks", locked, 1'b1);
        wr(A0, K0, 1'b1, "R4 k0"); wr(A1, K0, 1'b1, "R4 k0 on kick1");
        check("R11 key0 on kick1 locks", locked, 1'b1);

        // Near-miss values
        wr(A0, K0 ^ 32'h8000_0000, 1'b1, "R4 near k0");
        check("R7 near key0 locked", locked, 1'b1);
        wr(A1, K1, 1'b1, "R4 k1 after near");
        check("R7 near key0 did not arm", locked, 1'b1);
        wr(A0, K0, 1'b1, "R4 k0"); wr(A1, K1 ^ 32'h1, 1'b1, "R4 near k1");
        check("R7 near key1 locks", locked, 1'b1);

        // Low address bits ignored
        wr(8'h6E, K0, 1'b1, "R4 k0 offset 6E"); wr(8'h73, K1, 1'b1, "R4 k1 offset 73");
        check("R5 low bits ignored", locked, 1'b0);

        // Reset while open
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R1 reset relocks", locked, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule